// File: doc/BRIEF.md
# Character Display Host Register Port

This block is the register port through which a host processor talks to a character display controller. Every access is a single-cycle strobe carrying a register select and a direction. It can be a status read, an instruction write, a data write or a data read. The block keeps a 7-bit address counter and a flag that says whether the counter points into display RAM or glyph RAM. It also holds an increment or decrement direction and a busy interval of fixed length. Display RAM holds 80 bytes, split into two 40-byte line windows that sit at non-adjacent addresses. Glyph RAM holds 64 bytes.

The control path has a two-state machine. In `ST_READY`, any accepted access (anything but a status read) takes the transition `GO_EXEC` to `ST_EXEC` and loads the interval counter. In `ST_EXEC`, the transition `HOLD` counts down, and when the count reaches zero the transition `DONE` returns to `ST_READY`. The busy flag is high in `ST_EXEC`. A status read can be made in either state, and it returns the flag with the live counter packed into one byte. Data reads come from a registered output.

Top module: `chardisp_hostport`

## Requirements
- R1: After reset the busy flag is 0, the counter is 00h, display RAM is selected, the direction is increment and every RAM byte is 00h. A status read therefore returns 00h.
- R2: A status read (host_rs=0, host_rw=1) puts {busy, counter[6:0]} on host_rdata in the cycle after the strobe. Bit 7 is the flag as it stood in the strobe cycle. The read never starts a busy interval.
- R3: Every accepted instruction, data write or data read keeps the busy flag at 1 for exactly BUSY_CYCLES cycles. Status reads strobed on edges 1 to BUSY_CYCLES after the accepting edge see 1, and the next status read sees 0.
- R4: While busy, instruction writes, data writes and data reads are ignored. The counter, selection, direction, RAM contents and host_rdata all stay unchanged.
- R5: Instruction 1aaaaaaa loads the counter with aaaaaaa and selects display RAM.
- R6: Instruction 01aaaaaa loads the counter with 0aaaaaa and selects glyph RAM.
- R7: Instruction 000001ds sets the direction: d=1 means increment and d=0 means decrement. The bit s has no effect.
- R8: A data write (host_rs=1, host_rw=0) stores host_wdata at the counter's location in the selected RAM and then steps the counter once.
- R9: A data read (host_rs=1, host_rw=1) presents the byte at the counter's location on host_rdata in the cycle after the strobe and then steps the counter once.
- R10: In display RAM, incrementing goes 27h to 40h and 67h to 00h. Decrementing goes 40h to 27h and 00h to 67h. Other addresses step by plus or minus 1.
- R11: In glyph RAM the counter wraps within 6 bits: 3Fh to 00h when incrementing and 00h to 3Fh when decrementing. Bit 6 stays 0.
- R12: Display addresses 00h–27h and 40h–67h map to 80 distinct bytes, kept apart from glyph RAM. Writes to 28h–3Fh or 68h–7Fh store nothing and reads there return 00h, but the counter still steps.
- R13: Any other instruction code is accepted and starts a busy interval, but it changes no counter, selection or direction state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | One-cycle access strobe |
| host_rs | input | 1 | Register select: 0 selects instruction/status, 1 selects data |
| host_rw | input | 1 | Direction: 1 is a read, 0 is a write |
| host_wdata | input | 8 | Instruction or write data |
| host_rdata | output | 8 | Registered status or read data |

## Verification
The cases that meet in one cycle are the end of a busy interval (the `DONE` transition) and a new strobe. A status read strobed on the last busy edge must still report busy, and an instruction strobed on that same edge must be dropped. The bench provokes both by counting edges from the accepting strobe. It places a status read on every edge of the interval and an address-set exactly on its final edge. It then judges the result with a later status read, expecting busy clear and the earlier counter value unchanged. A second case places an ignored data read next to busy status reads and requires host_rdata to keep its previous byte.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

    typedef enum logic {
        SEL_DISP  = 1'b0,
        SEL_GLYPH = 1'b1
    } ram_sel_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_STATUS,
        OP_INSTR,
        OP_WDATA,
        OP_RDATA
    } host_op_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_EXEC  = 1'b1
    } exec_state_e;

endpackage

// File: rtl/chardisp_exec_fsm.sv
module chardisp_exec_fsm
    import chardisp_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES - 1);

    exec_state_e state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READY;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions: GO_EXEC, HOLD, DONE
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_READY: begin
                if (start) begin
                    state_nx = ST_EXEC;
                    cnt_nx   = LOAD_VAL;
                end
            end
            ST_EXEC: begin
                if (cnt == '0) begin
                    state_nx = ST_READY;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_READY: busy = 1'b0;
            ST_EXEC:  busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/chardisp_addr_ctr.sv
module chardisp_addr_ctr
    import chardisp_pkg::*;
#(
    parameter int AC_W       = 7,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64,
    parameter int GLYPH_AW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AC_W-1:0] load_val,
    input  ram_sel_e        load_sel,
    input  logic            step,
    input  logic            mode_set,
    input  logic            mode_inc,
    output logic [AC_W-1:0] ac,
    output ram_sel_e        sel,
    output logic            dir_inc
);
    localparam logic [AC_W-1:0] L1_FIRST = '0;
    localparam logic [AC_W-1:0] L1_LAST  = AC_W'(LINE_LEN - 1);
    localparam logic [AC_W-1:0] L2_FIRST = AC_W'(LINE2_BASE);
    localparam logic [AC_W-1:0] L2_LAST  = AC_W'(LINE2_BASE + LINE_LEN - 1);

    logic [AC_W-1:0]     ac_step;
    logic [GLYPH_AW-1:0] g_next;

    always_comb begin
        g_next = dir_inc ? ac[GLYPH_AW-1:0] + GLYPH_AW'(1)
                         : ac[GLYPH_AW-1:0] - GLYPH_AW'(1);
        if (sel == SEL_GLYPH) begin
            ac_step = AC_W'(g_next);
        end else if (dir_inc) begin
            if (ac == L1_LAST)      ac_step = L2_FIRST;
            else if (ac == L2_LAST) ac_step = L1_FIRST;
            else                    ac_step = ac + AC_W'(1);
        end else begin
            if (ac == L2_FIRST)     ac_step = L1_LAST;
            else if (ac == L1_FIRST) ac_step = L2_LAST;
            else                    ac_step = ac - AC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac      <= '0;
            sel     <= SEL_DISP;
            dir_inc <= 1'b1;
        end else begin
            if (load) begin
                ac  <= load_val;
                sel <= load_sel;
            end else if (step) begin
                ac <= ac_step;
            end
            if (mode_set) dir_inc <= mode_inc;
        end
    end

endmodule

// File: rtl/chardisp_bank.sv
module chardisp_bank #(
    parameter int DEPTH  = 80,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic              in_range;

    assign in_range = (int'(idx) < DEPTH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && in_range) begin
            mem[idx] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (in_range) rdata = mem[idx];
    end

endmodule

// File: rtl/chardisp_hostport.sv
module chardisp_hostport
    import chardisp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LINE_LEN    = 40,
    parameter int LINE2_BASE  = 64,
    parameter int GLYPH_DEPTH = 64,
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic              host_rs,
    input  logic              host_rw,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    localparam int AC_W       = DATA_W - 1;
    localparam int GLYPH_AW   = $clog2(GLYPH_DEPTH);
    localparam int DISP_DEPTH = 2 * LINE_LEN;
    localparam int DIDX_W     = $clog2(DISP_DEPTH);

    host_op_e          op;
    logic              busy;
    logic              accept;
    logic [AC_W-1:0]   ac;
    ram_sel_e          sel;
    logic              dir_inc;
    logic              cmd_disp, cmd_glyph, cmd_mode;
    logic              load, step, mode_set;
    logic [AC_W-1:0]   load_val;
    ram_sel_e          load_sel;
    logic              disp_hit;
    logic [DIDX_W-1:0] disp_idx;
    logic [DATA_W-1:0] disp_rd, glyph_rd, mem_rd;

    // access decode
    always_comb begin
        op = OP_NONE;
        if (host_en) begin
            unique case ({host_rs, host_rw})
                2'b01: op = OP_STATUS;
                2'b00: op = OP_INSTR;
                2'b10: op = OP_WDATA;
                2'b11: op = OP_RDATA;
            endcase
        end
    end

    assign accept    = !busy && (op != OP_NONE) && (op != OP_STATUS);
    assign cmd_disp  = host_wdata[DATA_W-1];
    assign cmd_glyph = (host_wdata[DATA_W-1 -: 2] == 2'b01);
    assign cmd_mode  = (host_wdata[DATA_W-1:2] == (DATA_W-2)'(1));

    always_comb begin
        load     = 1'b0;
        step     = 1'b0;
        mode_set = 1'b0;
        load_val = host_wdata[AC_W-1:0];
        load_sel = SEL_DISP;
        if (accept) begin
            unique case (op)
                OP_INSTR: begin
                    if (cmd_disp) begin
                        load = 1'b1;
                    end else if (cmd_glyph) begin
                        load     = 1'b1;
                        load_val = AC_W'(host_wdata[GLYPH_AW-1:0]);
                        load_sel = SEL_GLYPH;
                    end else if (cmd_mode) begin
                        mode_set = 1'b1;
                    end
                end
                OP_WDATA, OP_RDATA: step = 1'b1;
                default: ;
            endcase
        end
    end

    // display address to storage index
    always_comb begin
        disp_hit = 1'b0;
        disp_idx = '0;
        if (int'(ac) < LINE_LEN) begin
            disp_hit = 1'b1;
            disp_idx = DIDX_W'(ac);
        end else if (int'(ac) >= LINE2_BASE && int'(ac) < LINE2_BASE + LINE_LEN) begin
            disp_hit = 1'b1;
            disp_idx = DIDX_W'(int'(ac) - LINE2_BASE + LINE_LEN);
        end
    end

    chardisp_exec_fsm #(
        .BUSY_CYCLES(BUSY_CYCLES)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .busy  (busy)
    );

    chardisp_addr_ctr #(
        .AC_W       (AC_W),
        .LINE_LEN   (LINE_LEN),
        .LINE2_BASE (LINE2_BASE),
        .GLYPH_AW   (GLYPH_AW)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .load_sel (load_sel),
        .step     (step),
        .mode_set (mode_set),
        .mode_inc (host_wdata[1]),
        .ac       (ac),
        .sel      (sel),
        .dir_inc  (dir_inc)
    );

    chardisp_bank #(
        .DEPTH  (DISP_DEPTH),
        .DATA_W (DATA_W),
        .IDX_W  (DIDX_W)
    ) u_disp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (accept && op == OP_WDATA && sel == SEL_DISP && disp_hit),
        .idx   (disp_idx),
        .wdata (host_wdata),
        .rdata (disp_rd)
    );

    chardisp_bank #(
        .DEPTH  (GLYPH_DEPTH),
        .DATA_W (DATA_W),
        .IDX_W  (GLYPH_AW)
    ) u_glyph (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (accept && op == OP_WDATA && sel == SEL_GLYPH),
        .idx   (ac[GLYPH_AW-1:0]),
        .wdata (host_wdata),
        .rdata (glyph_rd)
    );

    assign mem_rd = (sel == SEL_GLYPH) ? glyph_rd : (disp_hit ? disp_rd : '0);

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (op == OP_STATUS) begin
            host_rdata <= {busy, ac};
        end else if (accept && op == OP_RDATA) begin
            host_rdata <= mem_rd;
        end
    end

endmodule

// File: rtl/chardisp_hostport_chk.sv
module chardisp_hostport_chk
    import chardisp_pkg::*;
#(
    parameter int AC_W       = 7,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_en,
    input logic            host_rs,
    input logic            host_rw,
    input logic [AC_W:0]   host_rdata,
    input logic            busy,
    input logic [AC_W-1:0] ac,
    input ram_sel_e        sel,
    input logic            dir_inc
);
    localparam logic [AC_W-1:0] L1_LAST  = AC_W'(LINE_LEN - 1);
    localparam logic [AC_W-1:0] L2_FIRST = AC_W'(LINE2_BASE);

    logic is_status, is_other;
    assign is_status = host_en && !host_rs && host_rw;
    assign is_other  = host_en && !(!host_rs && host_rw);

    a_r2_status_value: assert property (@(posedge clk) disable iff (!rst_n)
        is_status |=> host_rdata == {$past(busy), $past(ac)});

    a_r2_status_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && is_status) |=> !busy);

    a_r3_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && is_other) |=> busy);

    a_r4_busy_holds_counter: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ac) && $stable(sel) && $stable(dir_inc)));

    a_r10_line1_to_line2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_en && host_rs && sel == SEL_DISP && dir_inc && ac == L1_LAST)
        |=> ac == L2_FIRST);

    a_r10_line2_to_line1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_en && host_rs && sel == SEL_DISP && !dir_inc && ac == L2_FIRST)
        |=> ac == L1_LAST);

    a_r11_glyph_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_GLYPH) |-> !ac[AC_W-1]);

endmodule

bind chardisp_hostport chardisp_hostport_chk #(
    .AC_W       (AC_W),
    .LINE_LEN   (LINE_LEN),
    .LINE2_BASE (LINE2_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_en    (host_en),
    .host_rs    (host_rs),
    .host_rw    (host_rw),
    .host_rdata (host_rdata),
    .busy       (busy),
    .ac         (ac),
    .sel        (sel),
    .dir_inc    (dir_inc)
);

// File: tb/chardisp_hostport_test.sv
`timescale 1ns/1ps
module chardisp_hostport_test;
    localparam int BUSY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_en = 1'b0;
    logic       host_rs = 1'b0;
    logic       host_rw = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    chardisp_hostport #(
        .DATA_W(8), .LINE_LEN(40), .LINE2_BASE(64),
        .GLYPH_DEPTH(64), .BUSY_CYCLES(BUSY)
    ) uut (
        .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_rs(host_rs),
        .host_rw(host_rw), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one strobe; returns at the negedge after the sampling edge
    task automatic acc(input logic rs, input logic rw, input logic [7:0] d);
        host_rs = rs; host_rw = rw; host_wdata = d; host_en = 1'b1;
        @(negedge clk);
        host_en = 1'b0;
    endtask

    task automatic settle();
        repeat (BUSY) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] c);
        acc(1'b0, 1'b0, c); settle();
    endtask
    task automatic wr(input logic [7:0] d);
        acc(1'b1, 1'b0, d); settle();
    endtask
    task automatic rd_chk(input string req, input logic [7:0] exp);
        acc(1'b1, 1'b1, 8'h00); chk(req, host_rdata, exp); settle();
    endtask
    task automatic st_chk(input string req, input logic [7:0] exp);
        acc(1'b0, 1'b1, 8'h00); chk(req, host_rdata, exp);
    endtask

    task automatic t_reset();
        st_chk("R1 reset status", 8'h00);
        rd_chk("R1 reset ram byte", 8'h00);
        st_chk("R1 increment after reset", 8'h01);
    endtask

    task automatic t_busy_window();
        acc(1'b0, 1'b0, 8'h85);                         // R5 set display 05h
        for (int k = 1; k <= BUSY; k++) st_chk("R3 busy window", 8'h85);
        st_chk("R3 busy cleared", 8'h05);
        st_chk("R2 status sets no busy", 8'h05);
    endtask

    task automatic t_last_edge();
        acc(1'b0, 1'b0, 8'h85);
        for (int k = 1; k < BUSY; k++) st_chk("R3 busy window", 8'h85);
        acc(1'b0, 1'b0, 8'h8A);                         // final busy edge: dropped
        st_chk("R4 last busy edge instr dropped", 8'h05);
    endtask

    task automatic t_ignore();
        logic [7:0] held;
        acc(1'b0, 1'b0, 8'h90);
        acc(1'b0, 1'b0, 8'hA0);                         // ignored instruction
        acc(1'b1, 1'b0, 8'h55);                         // ignored write
        held = host_rdata;
        acc(1'b1, 1'b1, 8'h00);                         // ignored read
        chk("R4 ignored read keeps rdata", host_rdata, held);
        settle();
        st_chk("R4 counter untouched", 8'h10);
        rd_chk("R4 ignored write stored nothing", 8'h00);
    endtask

    task automatic t_line_gap_inc();
        cmd(8'hA6);                                     // 26h
        wr(8'hA1); wr(8'hA2); wr(8'hA3);
        st_chk("R10 27h->40h then 41h", 8'h41);
        cmd(8'hA6);
        rd_chk("R9 read 26h", 8'hA1);
        rd_chk("R9 read 27h", 8'hA2);
        rd_chk("R8 R9 read 40h", 8'hA3);
        cmd(8'hE7);                                     // 67h
        wr(8'hB7);
        st_chk("R10 67h->00h", 8'h00);
    endtask

    task automatic t_decrement();
        cmd(8'h04);                                     // decrement
        cmd(8'hC0); wr(8'hD0);
        st_chk("R7 R10 40h->27h", 8'h27);
        cmd(8'h80); wr(8'hE0);
        st_chk("R10 00h->67h", 8'h67);
        cmd(8'hC0);
        rd_chk("R12 line2 byte kept", 8'hD0);
        cmd(8'h07);                                     // increment, s=1
        cmd(8'h81); wr(8'h11);
        st_chk("R7 s bit no effect", 8'h02);
    endtask

    task automatic t_glyph();
        cmd(8'h7F);
        st_chk("R6 glyph set 3Fh", 8'h3F);
        wr(8'h5A);
        st_chk("R11 glyph 3Fh->00h", 8'h00);
        cmd(8'h04);
        cmd(8'h40); wr(8'h22);
        st_chk("R11 glyph 00h->3Fh", 8'h3F);
        rd_chk("R6 glyph byte readback", 8'h5A);
        st_chk("R11 glyph decrement", 8'h3E);
        cmd(8'h06);
        cmd(8'h80);
        rd_chk("R12 display separate from glyph", 8'hE0);
    endtask

    task automatic t_hole();
        cmd(8'hB0); wr(8'h99);
        st_chk("R12 hole still steps", 8'h31);
        cmd(8'hB0);
        rd_chk("R12 hole reads zero", 8'h00);
    endtask

    task automatic t_other_cmd();
        cmd(8'h85);
        acc(1'b0, 1'b0, 8'h01);
        st_chk("R13 other code sets busy", 8'h85);
        settle();
        st_chk("R13 other code no change", 8'h05);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        settle();
        t_busy_window();
        t_last_edge();
        settle();
        t_ignore();
        t_line_gap_inc();
        t_decrement();
        t_glyph();
        t_hole();
        t_other_cmd();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule